// File: doc/BRIEF.md
# Frame-Limited Gain Acquisition Sequencer

This block sets the gain of a video digitizer by stepping the code of a reference-voltage DAC. Gain is only adjusted inside a single acquisition window that spans exactly one video frame. At all other times the code is frozen, so the loop cannot wander after noise or small changes in signal strength.

A window is requested when lock is gained, either for the first time after reset or after lock has been lost. The host can also request a window by raising its enable bit. A request arms the sequencer. The window opens at the next frame-start pulse and closes at the frame-start pulse after that. When the window opens, the code is loaded with a nominal value. That value is raised by one half when the weak-signal boost bit is set.

For each line inside the window, the block averages a fixed number of samples taken in the blanking interval. It then moves the code one step toward the level that makes blank read about a quarter of full scale.

Top module: `agc_frame_seq`

## Requirements
- R1: While reset is asserted and right after it, `ref_code_o` equals CODE_NOM (default 128), and `busy_o` and `done_o` are both 0.
- R2: A sequence is requested by a rising edge of `lock_i`. This includes the first high level sampled after reset. The window then runs from the next sampled `frame_start_i` pulse to the following one, and `busy_o` is 1 for exactly that span.
- R3: When lock drops and later returns while the block is idle, a new sequence is requested.
- R4: A rising edge of `host_agc_en_i` requests a sequence. Keeping the bit high does not request another one.
- R5: A request that arrives while a sequence is armed or running is ignored. It does not extend the window and it does not start another one.
- R6: `done_o` is 1 for exactly one cycle. That cycle is the one in which `busy_o` falls at the end of a window.
- R7: When the window opens, `ref_code_o` is loaded with CODE_NOM if `gain_boost_i` is 0. If `gain_boost_i` is 1, it is loaded with CODE_NOM + CODE_NOM/2 (default 192).
- R8: The line measure is the mean of the first 2^AVG_LOG2 samples taken while `blank_i` is high (default 4 samples, mean truncated). A blank interval with fewer samples than that yields no measure.
- R9: Outside a window, `ref_code_o` does not change, whatever happens on the sample and blank inputs.
- R10: Within a window, each line's measure is compared with TARGET ± TOL (default 64 ± 2). A measure below the band raises the code by 1. A measure above the band lowers it by 1. A measure inside the band leaves it unchanged. The code saturates at 0 and at its maximum, so it moves by at most one step per line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | DW (8) | Digitized video sample |
| blank_i | input | 1 | High during the blanking interval of a line |
| frame_start_i | input | 1 | One-cycle pulse at the start of each frame |
| lock_i | input | 1 | Sync lock status |
| host_agc_en_i | input | 1 | Host request bit; a rising edge requests a sequence |
| gain_boost_i | input | 1 | Weak-signal gain boost select |
| ref_code_o | output | CW (8) | Reference DAC code |
| busy_o | output | 1 | Acquisition window open |
| done_o | output | 1 | One-cycle pulse at the end of a window |

## Verification
The bench builds the block with its defaults:
- 8-bit samples and codes.
- A four-sample blank average.
- A nominal code of 128, which becomes 192 under boost.
- A target band of 62 to 66.

With these values, a window of 70 dark lines drives the code from 192 into its upper limit of 255. A window of 140 bright lines drives it from 128 down to 0. Both saturation ends are therefore reached within one frame each. The short four-sample window also lets random blank lengths of one to six samples produce both valid and discarded line measures.

// File: rtl/agc_pkg.sv
package agc_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_ARMED = 2'd1,
      SEQ_RUN   = 2'd2
   } seq_state_t;

   function automatic int unsigned boosted_nominal(input int unsigned nom);
      return nom + (nom >> 1);
   endfunction

endpackage

// File: rtl/agc_seq_ctrl.sv
module agc_seq_ctrl
   import agc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic frame_start_i,
   input  logic lock_i,
   input  logic host_agc_en_i,
   output logic load_o,
   output logic run_o,
   output logic done_o
);

   seq_state_t state_q;
   logic       lock_q;
   logic       en_q;
   logic       trig;

   assign trig   = (lock_i & ~lock_q) | (host_agc_en_i & ~en_q);
   assign load_o = (state_q == SEQ_ARMED) & frame_start_i;
   assign run_o  = (state_q == SEQ_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         lock_q  <= 1'b0;
         en_q    <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         lock_q <= lock_i;
         en_q   <= host_agc_en_i;
         done_o <= 1'b0;
         unique case (state_q)
            SEQ_IDLE:  if (trig) state_q <= SEQ_ARMED;
            SEQ_ARMED: if (frame_start_i) state_q <= SEQ_RUN;
            SEQ_RUN:   if (frame_start_i) begin
               state_q <= SEQ_IDLE;
               done_o  <= 1'b1;
            end
            default:   state_q <= SEQ_IDLE;
         endcase
      end
   end

   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_done_ends_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !run_o);
   p_no_retrigger_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && !frame_start_i) |=> run_o);
   p_run_ends_on_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && frame_start_i) |=> (!run_o && done_o));

endmodule

// File: rtl/agc_blank_avg.sv
module agc_blank_avg #(
   parameter int DW       = 8,
   parameter int AVG_LOG2 = 2,
   parameter bit ROUND    = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] sample_i,
   input  logic          blank_i,
   output logic          avg_valid_o,
   output logic [DW-1:0] avg_o
);

   localparam int NSAMP = 1 << AVG_LOG2;
   localparam int SW    = DW + AVG_LOG2;
   localparam int CNTW  = AVG_LOG2 + 1;

   initial begin
      assert (AVG_LOG2 >= 0 && AVG_LOG2 <= 8) else $error("AVG_LOG2 out of range");
      assert (DW >= 2) else $error("DW too small");
   end

   logic [SW-1:0]   sum_q;
   logic [CNTW-1:0] cnt_q;
   logic            blank_q;
   logic [SW-1:0]   mean;

   generate
      if (ROUND && AVG_LOG2 > 0) begin : g_round
         logic [SW:0] biased;
         assign biased = {1'b0, sum_q} + (SW+1)'(NSAMP / 2);
         assign mean   = SW'(biased >> AVG_LOG2);
      end else begin : g_trunc
         assign mean = sum_q >> AVG_LOG2;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q       <= '0;
         cnt_q       <= '0;
         blank_q     <= 1'b0;
         avg_valid_o <= 1'b0;
         avg_o       <= '0;
      end else begin
         blank_q     <= blank_i;
         avg_valid_o <= 1'b0;
         if (blank_i) begin
            if (cnt_q < CNTW'(NSAMP)) begin
               sum_q <= sum_q + SW'(sample_i);
               cnt_q <= cnt_q + 1'b1;
            end
         end else if (blank_q) begin
            avg_valid_o <= (cnt_q == CNTW'(NSAMP));
            avg_o       <= (mean > SW'({DW{1'b1}})) ? {DW{1'b1}} : mean[DW-1:0];
            sum_q       <= '0;
            cnt_q       <= '0;
         end
      end
   end

   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNTW'(NSAMP));
   p_valid_after_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
      avg_valid_o |-> !blank_q);

endmodule

// File: rtl/agc_code_step.sv
module agc_code_step #(
   parameter int DW     = 8,
   parameter int CW     = 8,
   parameter int TARGET = 64,
   parameter int TOL    = 2,
   parameter int NOM    = 128,
   parameter int BOOST  = 192
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          boost_i,
   input  logic          run_i,
   input  logic          avg_valid_i,
   input  logic [DW-1:0] avg_i,
   output logic [CW-1:0] code_o
);

   localparam logic [CW-1:0] CODE_MAX = {CW{1'b1}};
   localparam logic [DW-1:0] LO_EDGE  = DW'(TARGET - TOL);
   localparam logic [DW-1:0] HI_EDGE  = DW'(TARGET + TOL);

   logic too_dark;
   logic too_bright;

   assign too_dark   = avg_i < LO_EDGE;
   assign too_bright = avg_i > HI_EDGE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o <= CW'(NOM);
      end else if (load_i) begin
         code_o <= boost_i ? CW'(BOOST) : CW'(NOM);
      end else if (run_i && avg_valid_i) begin
         if (too_dark && code_o != CODE_MAX)
            code_o <= code_o + 1'b1;
         else if (too_bright && code_o != '0)
            code_o <= code_o - 1'b1;
      end
   end

   p_hold_outside_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !load_i) |=> $stable(code_o));
   p_one_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> (code_o == $past(code_o) || code_o == $past(code_o) + 1'b1
                   || code_o == $past(code_o) - 1'b1));
   p_load_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (code_o == CW'(NOM) || code_o == CW'(BOOST)));

endmodule

// File: rtl/agc_frame_seq.sv
module agc_frame_seq #(
   parameter int DW       = 8,
   parameter int CW       = 8,
   parameter int AVG_LOG2 = 2,
   parameter bit ROUND    = 1'b0,
   parameter int TARGET   = 64,
   parameter int TOL      = 2,
   parameter int CODE_NOM = 128
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] sample_i,
   input  logic          blank_i,
   input  logic          frame_start_i,
   input  logic          lock_i,
   input  logic          host_agc_en_i,
   input  logic          gain_boost_i,
   output logic [CW-1:0] ref_code_o,
   output logic          busy_o,
   output logic          done_o
);

   localparam int CODE_BOOST = int'(agc_pkg::boosted_nominal(CODE_NOM));

   initial begin
      assert (CODE_BOOST <= (1 << CW) - 1) else $error("boosted nominal exceeds code range");
      assert (TARGET - TOL >= 0 && TARGET + TOL < (1 << DW)) else $error("target band outside sample range");
      assert (CW >= 2 && CW <= 16) else $error("CW out of range");
   end

   logic          load;
   logic          run;
   logic          avg_valid;
   logic [DW-1:0] avg;

   agc_seq_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_start_i (frame_start_i),
      .lock_i        (lock_i),
      .host_agc_en_i (host_agc_en_i),
      .load_o        (load),
      .run_o         (run),
      .done_o        (done_o)
   );

   agc_blank_avg #(.DW(DW), .AVG_LOG2(AVG_LOG2), .ROUND(ROUND)) u_avg (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample_i    (sample_i),
      .blank_i     (blank_i),
      .avg_valid_o (avg_valid),
      .avg_o       (avg)
   );

   agc_code_step #(
      .DW(DW), .CW(CW), .TARGET(TARGET), .TOL(TOL),
      .NOM(CODE_NOM), .BOOST(CODE_BOOST)
   ) u_step (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load),
      .boost_i     (gain_boost_i),
      .run_i       (run),
      .avg_valid_i (avg_valid),
      .avg_i       (avg),
      .code_o      (ref_code_o)
   );

   assign busy_o = run;

endmodule

// File: tb/tb_agc_frame_seq.sv
module tb_agc_frame_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] sample_i = '0;
   logic       blank_i = 1'b0;
   logic       frame_start_i = 1'b0;
   logic       lock_i = 1'b0;
   logic       host_agc_en_i = 1'b0;
   logic       gain_boost_i = 1'b0;
   logic [7:0] ref_code_o;
   logic       busy_o;
   logic       done_o;

   int checks = 0;
   int errors = 0;
   int exp_code = 128;
   logic [7:0] line_buf [0:7];

   always #10 clk = ~clk;

   agc_frame_seq dut (
      .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .blank_i(blank_i),
      .frame_start_i(frame_start_i), .lock_i(lock_i), .host_agc_en_i(host_agc_en_i),
      .gain_boost_i(gain_boost_i), .ref_code_o(ref_code_o), .busy_o(busy_o), .done_o(done_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic int step_model(input int code, input int avg);
      if (avg < 62 && code < 255) return code + 1;
      if (avg > 66 && code > 0) return code - 1;
      return code;
   endfunction

   // Drives one line whose blank interval holds n samples from line_buf;
   // updates the expected code when in_run.
   task automatic do_line(input int n, input bit in_run);
      int sum = 0;
      blank_i = 1'b1;
      for (int i = 0; i < n; i++) begin
         sample_i = line_buf[i];
         if (i < 4) sum += int'(line_buf[i]);
         tick();
      end
      blank_i = 1'b0;
      sample_i = 8'd0;
      repeat (3) tick();
      if (in_run && n >= 4) exp_code = step_model(exp_code, sum / 4);
   endtask

   task automatic flat_line(input int v, input int n, input bit in_run);
      for (int i = 0; i < 8; i++) line_buf[i] = 8'(v);
      do_line(n, in_run);
   endtask

   task automatic frame_pulse();
      frame_start_i = 1'b1;
      tick();
      frame_start_i = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      tick();
      chk("R1 code in reset", int'(ref_code_o), 128);
      repeat (2) tick();
      rst_n = 1'b1;
      tick();
      chk("R1 code", int'(ref_code_o), 128);
      chk("R1 busy", int'(busy_o), 0);
      chk("R1 done", int'(done_o), 0);

      // R9: idle lines have no effect
      for (int k = 0; k < 5; k++) flat_line(5, 4, 1'b0);
      frame_pulse();
      chk("R9 idle hold", int'(ref_code_o), 128);
      chk("R2 no window without request", int'(busy_o), 0);

      // R2: first lock, random lines
      lock_i = 1'b1;
      tick();
      chk("R2 armed not busy", int'(busy_o), 0);
      lock_i = 1'b0; tick(); lock_i = 1'b1; tick();   // R5 retrigger while armed
      frame_pulse();
      chk("R2 busy at window open", int'(busy_o), 1);
      chk("R7 nominal load", int'(ref_code_o), 128);
      exp_code = 128;
      for (int k = 0; k < 40; k++) begin
         int n = 1 + int'($urandom_range(5));
         int base = int'($urandom_range(120));
         for (int i = 0; i < 8; i++) line_buf[i] = 8'(base + int'($urandom_range(20)));
         do_line(n, 1'b1);
         chk("R8 R10 per-line code", int'(ref_code_o), exp_code);
      end
      // directed band edges
      flat_line(64, 4, 1'b1); chk("R10 in band", int'(ref_code_o), exp_code);
      flat_line(61, 4, 1'b1); chk("R10 below band", int'(ref_code_o), exp_code);
      flat_line(67, 4, 1'b1); chk("R10 above band", int'(ref_code_o), exp_code);
      flat_line(0, 3, 1'b1);  chk("R8 short blank ignored", int'(ref_code_o), exp_code);
      frame_pulse();
      chk("R6 done at end", int'(done_o), 1);
      chk("R2 busy falls", int'(busy_o), 0);
      chk("R8 final code", int'(ref_code_o), exp_code);
      tick();
      chk("R6 done one cycle", int'(done_o), 0);
      for (int k = 0; k < 4; k++) flat_line(250, 4, 1'b0);
      chk("R9 hold after window", int'(ref_code_o), exp_code);

      // R3: lock loss and regain, with boost
      lock_i = 1'b0; repeat (3) tick();
      lock_i = 1'b1; gain_boost_i = 1'b1; tick();
      frame_pulse();
      chk("R3 regain starts window", int'(busy_o), 1);
      chk("R7 boosted load", int'(ref_code_o), 192);
      exp_code = 192;
      host_agc_en_i = 1'b1; tick(); host_agc_en_i = 1'b0;  // R5 ignored
      lock_i = 1'b0; tick(); lock_i = 1'b1; tick();        // R5 ignored
      for (int k = 0; k < 70; k++) flat_line(10, 5, 1'b1);
      chk("R10 upper saturation", int'(ref_code_o), 255);
      chk("R5 still running", int'(busy_o), 1);
      frame_pulse();
      chk("R6 done", int'(done_o), 1);
      gain_boost_i = 1'b0;
      repeat (3) tick();
      frame_pulse();
      chk("R5 no extra window", int'(busy_o), 0);
      chk("R9 hold", int'(ref_code_o), 255);

      // R4: host enable
      host_agc_en_i = 1'b1; tick();
      frame_pulse();
      chk("R4 host starts window", int'(busy_o), 1);
      chk("R7 nominal again", int'(ref_code_o), 128);
      for (int k = 0; k < 140; k++) flat_line(250, 4, 1'b1);
      chk("R10 lower saturation", int'(ref_code_o), 0);
      frame_pulse();
      chk("R6 done host window", int'(done_o), 1);
      repeat (2) tick();
      frame_pulse();
      chk("R4 level no retrigger", int'(busy_o), 0);
      frame_pulse();
      chk("R4 level no retrigger 2", int'(busy_o), 0);
      chk("R9 hold final", int'(ref_code_o), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule